// File: doc/BRIEF.md
# Superscalar Issue Port Allocator

This block sits between decode and the execution units of a four-wide core. Each cycle it may take in a group of up to four decoded micro-ops. It places them in a short in-order holding queue. It then issues as many of the oldest queued micro-ops as the ports allow: three integer ALU ports and one memory port. No-op micro-ops use up issue width but take no port. A micro-op cannot issue alongside an older micro-op of the same cycle that writes the register it reads. Issue stops at the first micro-op that cannot go, and that micro-op is the first one tried on the next cycle.

Each issued ALU micro-op appears on the lowest free ALU port, in program order. A load or store appears on the memory port. A retire count reports how many micro-ops left the queue. Because of this count, the sustained rate of a no-op stream (four per cycle), of independent adds (three per cycle) and of a dependent chain (one per cycle) can be read directly at the ports.

Top module: `issue_port_alloc`

## Requirements
- R1: While `rst` is high at a clock edge, the queue is emptied and every port-valid output and `retireCount` are zero afterwards. A group presented during reset is not kept, and `inReady` is high after reset.
- R2: `inReady` is high exactly when the queue holds at most DEPTH-4 micro-ops. A group is taken when `inValid` and `inReady` are both high. Slot 0 is the oldest. Slots whose 2-bit class is 11 (empty) are dropped, and the remaining slots keep their order.
- R3: At most four micro-ops issue per cycle, strictly oldest first. When a micro-op is blocked, every younger one waits, and the blocked one is the oldest candidate on the next cycle, ahead of any newer group.
- R4: At most three ALU micro-ops (class 01) issue per cycle. The k-th issued ALU micro-op of a cycle drives ALU port k, so port valids are always filled from port 0 upward.
- R5: At most one load/store micro-op (class 10) issues per cycle, on the memory port. A second one waits.
- R6: A no-op (class 00) issues and is counted in `retireCount` but drives no port.
- R7: A non-no-op micro-op does not issue in the same cycle as an older issuing non-no-op whose destination-valid flag is set and whose destination equals its source. A clear destination-valid flag creates no dependency.
- R8: Port outputs and `retireCount` are registered. A group taken at clock edge N is first issued at edge N+1, and `retireCount` equals the number of micro-ops issued at that edge (0 to 4).
- R9: With DEPTH=12, a continuous stream sustains four no-ops per cycle, three independent ALU micro-ops per cycle, and one micro-op per cycle for a chain of adds that each read the previous result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Group offered this cycle |
| inReady | output | 1 | Queue has room for a full group |
| inClass | input | 8 | Per-slot class, slot s at bits [2s+1:2s] |
| inDst | input | 16 | Per-slot destination register, slot s at [4s+3:4s] |
| inSrc | input | 16 | Per-slot source register, slot s at [4s+3:4s] |
| inDstValid | input | 4 | Per-slot destination-valid flag |
| aluValid | output | 3 | ALU port issue valid, one bit per port |
| aluDst | output | 12 | ALU port destination register, port p at [4p+3:4p] |
| aluSrc | output | 12 | ALU port source register, port p at [4p+3:4p] |
| memValid | output | 1 | Memory port issue valid |
| memDst | output | 4 | Memory port destination register |
| memSrc | output | 4 | Memory port source register |
| retireCount | output | 3 | Micro-ops issued at the last edge |

## Verification
The hardest situation to reach is a stalled micro-op carried over and issued together with the head of a newer group. This shows that the held micro-op really goes first, and that the no-ops behind it waited rather than slipping past. The bench offers a group with two loads followed by no-ops, and then offers a second group on the very next cycle, while the second load is still held. Back-pressure is reached with a long stream of independent ALU groups. The stream outruns the three ALU ports, fills the queue past DEPTH-4 so that `inReady` falls, and is then checked for an exact count of three-per-cycle cycles.

// File: rtl/issue_pkg.sv
package issue_pkg;
  parameter int GROUP = 4;
  parameter int ALU_PORTS = 3;
  parameter int REG_W = 4;
  localparam int SLOT_W = $clog2(GROUP);
  localparam int CNT_W = $clog2(GROUP + 1);
  localparam int AIDX_W = $clog2(ALU_PORTS + 1);

  typedef enum logic [1:0] {
    CLS_NOP   = 2'b00,
    CLS_ALU   = 2'b01,
    CLS_MEM   = 2'b10,
    CLS_EMPTY = 2'b11
  } uopClass_t;

  typedef struct packed {
    uopClass_t        cls;
    logic [REG_W-1:0] dst;
    logic [REG_W-1:0] src;
    logic             dstValid;
  } uop_t;

  // strobes from control to datapath
  typedef struct packed {
    logic [CNT_W-1:0]                   issueCount;
    logic [ALU_PORTS-1:0]               aluHit;
    logic [ALU_PORTS-1:0][SLOT_W-1:0]   aluSlot;
    logic                               memHit;
    logic [SLOT_W-1:0]                  memSlot;
  } issueStrobe_t;
endpackage

// File: rtl/issue_ctrl.sv
module issue_ctrl
  import issue_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  uop_t               win [GROUP],
  input  logic [GROUP-1:0]   winValid,
  output issueStrobe_t       strobe
);
  logic [GROUP-1:0]  issueMask;
  logic [GROUP-1:0]  memMask;
  logic [AIDX_W-1:0] aluUsed;
  logic              memUsed;
  logic              stop;
  logic              blocked;

  // in-order scan of the window: stop at the first micro-op that cannot go
  always_comb begin
    strobe    = '0;
    issueMask = '0;
    memMask   = '0;
    aluUsed   = '0;
    memUsed   = 1'b0;
    stop      = 1'b0;
    blocked   = 1'b0;
    for (int i = 0; i < GROUP; i++) begin
      blocked = !winValid[i] || (win[i].cls == CLS_EMPTY);
      if (win[i].cls != CLS_NOP) begin
        for (int j = 0; j < i; j++) begin
          if (issueMask[j] && win[j].cls != CLS_NOP && win[j].dstValid &&
              win[j].dst == win[i].src)
            blocked = 1'b1;
        end
      end
      if (win[i].cls == CLS_ALU && aluUsed >= AIDX_W'(ALU_PORTS)) blocked = 1'b1;
      if (win[i].cls == CLS_MEM && memUsed) blocked = 1'b1;
      if (!stop && !blocked) begin
        issueMask[i] = 1'b1;
        if (win[i].cls == CLS_ALU) begin
          strobe.aluHit[aluUsed]  = 1'b1;
          strobe.aluSlot[aluUsed] = SLOT_W'(i);
          aluUsed = aluUsed + AIDX_W'(1);
        end
        if (win[i].cls == CLS_MEM) begin
          memUsed        = 1'b1;
          memMask[i]     = 1'b1;
          strobe.memHit  = 1'b1;
          strobe.memSlot = SLOT_W'(i);
        end
      end else begin
        stop = 1'b1;
      end
    end
    strobe.issueCount = CNT_W'($countones(issueMask));
  end

  // R3: issue set is always an oldest-first prefix of the window
  generate
    for (genvar j = 1; j < GROUP; j++) begin : g_prefix
      assert_in_order_R3: assert property (@(posedge clk) disable iff (rst)
        issueMask[j] |-> issueMask[j-1]);
    end
    // R7: no issued reader sees a same-cycle older writer
    for (genvar a = 0; a < GROUP; a++) begin : g_rawA
      for (genvar b = a + 1; b < GROUP; b++) begin : g_rawB
        assert_no_raw_R7: assert property (@(posedge clk) disable iff (rst)
          (issueMask[a] && issueMask[b] && win[a].dstValid &&
           win[a].cls != CLS_NOP && win[b].cls != CLS_NOP)
          |-> (win[b].src != win[a].dst));
      end
    end
  endgenerate

  // R5: only one memory micro-op leaves per cycle
  assert_mem_single_R5: assert property (@(posedge clk) disable iff (rst)
    $countones(memMask & issueMask) <= 1);
endmodule

// File: rtl/issue_dpath.sv
module issue_dpath
  import issue_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  uop_t                         inUops [GROUP],
  input  issueStrobe_t                 strobe,
  output uop_t                         win [GROUP],
  output logic [GROUP-1:0]             winValid,
  output logic                         inReady,
  output logic [ALU_PORTS-1:0]         aluValid,
  output logic [ALU_PORTS*REG_W-1:0]   aluDst,
  output logic [ALU_PORTS*REG_W-1:0]   aluSrc,
  output logic                         memValid,
  output logic [REG_W-1:0]             memDst,
  output logic [REG_W-1:0]             memSrc,
  output logic [CNT_W-1:0]             retireCount
);
  localparam int OCC_W = $clog2(DEPTH + 1);

  uop_t             bufQ    [DEPTH];
  uop_t             nextBuf [DEPTH];
  logic [OCC_W-1:0] occQ;
  logic [OCC_W-1:0] nextOcc;
  logic [OCC_W-1:0] wrPos;
  logic             accept;

  assign inReady = (int'(occQ) <= DEPTH - GROUP);
  assign accept  = inValid && inReady;

  generate
    for (genvar w = 0; w < GROUP; w++) begin : g_win
      assign win[w]      = bufQ[w];
      assign winValid[w] = (w < int'(occQ));
    end
  endgenerate

  // drop the issued head, then append the non-empty slots of a new group
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      if (k + int'(strobe.issueCount) < DEPTH)
        nextBuf[k] = bufQ[k + int'(strobe.issueCount)];
      else
        nextBuf[k] = '0;
    end
    wrPos = occQ - OCC_W'(strobe.issueCount);
    if (accept) begin
      for (int s = 0; s < GROUP; s++) begin
        if (inUops[s].cls != CLS_EMPTY) begin
          if (int'(wrPos) < DEPTH) nextBuf[wrPos] = inUops[s];
          wrPos = wrPos + OCC_W'(1);
        end
      end
    end
    nextOcc = wrPos;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occQ        <= '0;
      aluValid    <= '0;
      memValid    <= 1'b0;
      retireCount <= '0;
      aluDst      <= '0;
      aluSrc      <= '0;
      memDst      <= '0;
      memSrc      <= '0;
      for (int k = 0; k < DEPTH; k++) bufQ[k] <= '0;
    end else begin
      occQ        <= nextOcc;
      for (int k = 0; k < DEPTH; k++) bufQ[k] <= nextBuf[k];
      aluValid    <= strobe.aluHit;
      memValid    <= strobe.memHit;
      retireCount <= strobe.issueCount;
      for (int p = 0; p < ALU_PORTS; p++) begin
        aluDst[p*REG_W +: REG_W] <= win[strobe.aluSlot[p]].dst;
        aluSrc[p*REG_W +: REG_W] <= win[strobe.aluSlot[p]].src;
      end
      memDst <= win[strobe.memSlot].dst;
      memSrc <= win[strobe.memSlot].src;
    end
  end

  // R2: the queue never holds more than DEPTH entries
  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    int'(occQ) <= DEPTH);

  // R4: ALU ports fill from port 0 upward
  generate
    for (genvar p = 1; p < ALU_PORTS; p++) begin : g_pack
      assert_alu_packed_R4: assert property (@(posedge clk) disable iff (rst)
        aluValid[p] |-> aluValid[p-1]);
    end
  endgenerate

  // R6: port users never exceed the retire count (no-ops add to it only)
  assert_retire_ports_R6: assert property (@(posedge clk) disable iff (rst)
    int'(retireCount) >= $countones(aluValid) + int'(memValid));

  // R8: an empty queue issues nothing at the next edge
  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (occQ == '0) |=> (retireCount == '0));
endmodule

// File: rtl/issue_port_alloc.sv
module issue_port_alloc
  import issue_pkg::*;
#(
  parameter int DEPTH = 12
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  output logic                         inReady,
  input  logic [2*GROUP-1:0]           inClass,
  input  logic [GROUP*REG_W-1:0]       inDst,
  input  logic [GROUP*REG_W-1:0]       inSrc,
  input  logic [GROUP-1:0]             inDstValid,
  output logic [ALU_PORTS-1:0]         aluValid,
  output logic [ALU_PORTS*REG_W-1:0]   aluDst,
  output logic [ALU_PORTS*REG_W-1:0]   aluSrc,
  output logic                         memValid,
  output logic [REG_W-1:0]             memDst,
  output logic [REG_W-1:0]             memSrc,
  output logic [CNT_W-1:0]             retireCount
);
  uop_t             inUops [GROUP];
  uop_t             win    [GROUP];
  logic [GROUP-1:0] winValid;
  issueStrobe_t     strobe;

  generate
    for (genvar s = 0; s < GROUP; s++) begin : g_unpack
      assign inUops[s].cls      = uopClass_t'(inClass[2*s +: 2]);
      assign inUops[s].dst      = inDst[s*REG_W +: REG_W];
      assign inUops[s].src      = inSrc[s*REG_W +: REG_W];
      assign inUops[s].dstValid = inDstValid[s];
    end
  endgenerate

  issue_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .win      (win),
    .winValid (winValid),
    .strobe   (strobe)
  );

  issue_dpath #(.DEPTH(DEPTH)) u_dpath (
    .clk         (clk),
    .rst         (rst),
    .inValid     (inValid),
    .inUops      (inUops),
    .strobe      (strobe),
    .win         (win),
    .winValid    (winValid),
    .inReady     (inReady),
    .aluValid    (aluValid),
    .aluDst      (aluDst),
    .aluSrc      (aluSrc),
    .memValid    (memValid),
    .memDst      (memDst),
    .memSrc      (memSrc),
    .retireCount (retireCount)
  );
endmodule

// File: tb/issue_port_alloc_bench.sv
`timescale 1ns/1ps
module issue_port_alloc_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [7:0]  inClass = 8'hFF;
  logic [15:0] inDst = '0;
  logic [15:0] inSrc = '0;
  logic [3:0]  inDstValid = '0;
  logic [2:0]  aluValid;
  logic [11:0] aluDst;
  logic [11:0] aluSrc;
  logic        memValid;
  logic [3:0]  memDst;
  logic [3:0]  memSrc;
  logic [2:0]  retireCount;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [1:0] NOP = 2'b00, ALU = 2'b01, MEM = 2'b10, EMP = 2'b11;

  always #2.5 clk = ~clk;

  issue_port_alloc u_issue_port_alloc (
    .clk(clk), .rst(rst), .inValid(inValid), .inReady(inReady),
    .inClass(inClass), .inDst(inDst), .inSrc(inSrc), .inDstValid(inDstValid),
    .aluValid(aluValid), .aluDst(aluDst), .aluSrc(aluSrc),
    .memValid(memValid), .memDst(memDst), .memSrc(memSrc),
    .retireCount(retireCount)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    check(act == exp, tag, act, exp);
  endtask

  task automatic clearSlots();
    inClass = 8'hFF; inDst = '0; inSrc = '0; inDstValid = '0;
  endtask

  task automatic setSlot(input int s, input logic [1:0] c, input logic [3:0] d,
                         input logic [3:0] sr, input logic dv);
    inClass[2*s +: 2] = c;
    inDst[4*s +: 4]   = d;
    inSrc[4*s +: 4]   = sr;
    inDstValid[s]     = dv;
  endtask

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic pushGroup();
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    clearSlots();
  endtask

  task automatic drain();
    repeat (6) @(negedge clk);
  endtask

  task automatic testReset();
    @(negedge clk);
    rst = 1'b1;
    for (int s = 0; s < 4; s++) setSlot(s, NOP, 0, 0, 0);
    inValid = 1'b1;
    repeat (2) @(negedge clk);
    inValid = 1'b0;
    clearSlots();
    rst = 1'b0;
    chk("R1 retire after reset", retireCount, 0);
    chk("R1 alu valid after reset", aluValid, 0);
    chk("R1 mem valid after reset", memValid, 0);
    chk("R1 ready after reset", inReady, 1);
    @(negedge clk);
    chk("R1 group in reset not kept", retireCount, 0);
  endtask

  task automatic testNops();
    for (int s = 0; s < 4; s++) setSlot(s, NOP, 4'(s + 1), 0, 1);
    pushGroup();
    chk("R8 no issue at capture edge", retireCount, 0);
    @(negedge clk);
    chk("R6 four nops retire", retireCount, 4);
    chk("R6 nops use no alu port", aluValid, 0);
    chk("R6 nops use no mem port", memValid, 0);
    drain();
  endtask

  task automatic testAluLimit();
    for (int s = 0; s < 4; s++) setSlot(s, ALU, 4'(s + 1), 4'(s + 9), 1);
    pushGroup();
    @(negedge clk);
    chk("R4 three alu issue", retireCount, 3);
    chk("R4 alu ports full", aluValid, 3'b111);
    chk("R4 port0 dst", aluDst[3:0], 1);
    chk("R4 port1 dst", aluDst[7:4], 2);
    chk("R4 port2 dst", aluDst[11:8], 3);
    chk("R4 port2 src", aluSrc[11:8], 11);
    @(negedge clk);
    chk("R4 fourth alu next cycle", retireCount, 1);
    chk("R4 leftover on port0", aluValid, 3'b001);
    chk("R4 leftover dst", aluDst[3:0], 4);
    drain();
  endtask

  task automatic testMix();
    setSlot(0, ALU, 1, 9, 1);
    setSlot(1, ALU, 2, 10, 1);
    setSlot(2, MEM, 5, 11, 1);
    setSlot(3, ALU, 3, 12, 1);
    pushGroup();
    @(negedge clk);
    chk("R3 mixed group four wide", retireCount, 4);
    chk("R5 mem issues beside alus", memValid, 1);
    chk("R5 mem dst", memDst, 5);
    chk("R5 mem src", memSrc, 11);
    chk("R4 third alu skips mem slot", aluDst[11:8], 3);
    drain();
  endtask

  // held load goes first, ahead of a newer group; nops behind it wait
  task automatic testRetryOrder();
    setSlot(0, MEM, 6, 1, 1);
    setSlot(1, MEM, 7, 2, 1);
    setSlot(2, NOP, 0, 0, 0);
    setSlot(3, NOP, 0, 0, 0);
    pushGroup();
    for (int s = 0; s < 4; s++) setSlot(s, NOP, 0, 0, 0);
    pushGroup();
    chk("R5 second mem blocked", retireCount, 1);
    chk("R5 first mem dst", memDst, 6);
    @(negedge clk);
    chk("R3 held mem plus three nops", retireCount, 4);
    chk("R3 held mem issued first", memDst, 7);
    chk("R3 held mem valid", memValid, 1);
    @(negedge clk);
    chk("R3 tail of newer group", retireCount, 3);
    chk("R3 no mem in tail", memValid, 0);
    drain();
  endtask

  task automatic testChain();
    for (int s = 0; s < 4; s++) setSlot(s, ALU, 1, 1, 1);
    pushGroup();
    for (int c = 0; c < 4; c++) begin
      @(negedge clk);
      chk("R7 dependent chain one per cycle", retireCount, 1);
    end
    @(negedge clk);
    chk("R7 chain drained", retireCount, 0);
    // dstValid clear: no dependency
    setSlot(0, ALU, 2, 3, 0);
    setSlot(1, ALU, 4, 2, 1);
    pushGroup();
    @(negedge clk);
    chk("R7 clear dst-valid no stall", retireCount, 2);
    drain();
  endtask

  task automatic testEmptySlots();
    setSlot(0, ALU, 1, 9, 1);
    setSlot(1, EMP, 2, 9, 1);
    setSlot(2, EMP, 3, 9, 1);
    setSlot(3, ALU, 4, 10, 1);
    pushGroup();
    @(negedge clk);
    chk("R2 empty slots dropped", retireCount, 2);
    chk("R2 kept order port1 dst", aluDst[7:4], 4);
    @(negedge clk);
    chk("R2 nothing left", retireCount, 0);
    drain();
  endtask

  task automatic testNopStream();
    int bad = 0;
    for (int n = 0; n < 12; n++) begin
      if (n >= 2 && retireCount != 3'd4) bad++;
      if (n < 10) begin
        if (!inReady) bad++;
        for (int s = 0; s < 4; s++) setSlot(s, NOP, 0, 0, 0);
        inValid = 1'b1;
      end else begin
        inValid = 1'b0;
        clearSlots();
      end
      @(negedge clk);
    end
    chk("R9 nop stream four per cycle", bad, 0);
    drain();
  endtask

  task automatic testAluStream();
    int sent = 0, total = 0, threes = 0, over = 0;
    bit stalled = 1'b0;
    for (int c = 0; c < 40; c++) begin
      total += int'(retireCount);
      if (retireCount == 3'd3) threes++;
      if (retireCount > 3'd3) over++;
      if (sent < 8) begin
        if (inReady) begin
          for (int s = 0; s < 4; s++) setSlot(s, ALU, 4'(s + 1), 4'(s + 9), 1);
          inValid = 1'b1;
          sent++;
        end else begin
          stalled = 1'b1;
          inValid = 1'b0;
        end
      end else begin
        inValid = 1'b0;
        clearSlots();
      end
      @(negedge clk);
    end
    chk("R9 alu stream all retired", total, 32);
    chk("R9 alu stream three per cycle", threes, 10);
    chk("R4 alu stream never above three", over, 0);
    chk("R2 ready dropped under backlog", stalled, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testNops();
    testAluLimit();
    testMix();
    testRetryOrder();
    testChain();
    testEmptySlots();
    testNopStream();
    testAluStream();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule